// File: doc/BRIEF.md
# Shared Issue Queue Slot Allocator

This block keeps the books for a shared issue queue that several hardware threads fill. It does not hold any instructions. It counts how many slots each thread occupies and how many slots remain free in total. From those counts it decides whether a new instruction from a given thread may enter the queue. Each thread's occupancy is capped by a limit, and one of three sharing policies sets that limit. Under the open policy any thread may take the whole queue. Under the even-split policy the queue is divided evenly among the active threads. Under the percentage policy each thread may take a fixed share of the queue, and that share widens to the whole queue when only one thread is running.

The insert side is a valid/ready stream. `ins_ready` depends only on registered state and on `ins_tid`, never on `ins_valid` or on the release inputs. A cycle with `ins_valid` high and `ins_ready` low is not taken, and it raises `ins_err` for one cycle. The sender may hold `ins_valid` asserted to retry. The release side has no back-pressure: a release for a thread that holds at least one slot is always taken. The policy select, the percentage and the active-thread count are plain control inputs that are sampled every cycle. The per-thread limits follow them one cycle later.

Top module: `iq_alloc`

## Requirements
- R1: After reset, `free_total` equals NUM_ENTRIES, `full_total` is 0, every thread's free count equals NUM_ENTRIES, no thread is full and `ins_err` is 0.
- R2: An accepted insert (`ins_valid` and `ins_ready` both high) lowers `free_total` by one and raises the occupancy of thread `ins_tid` by one, both visible after the next clock edge.
- R3: A release (`rel_valid`) for a thread whose occupancy is nonzero lowers that thread's occupancy by one and raises `free_total` by one. A release for a thread with zero occupancy changes no count and no flag.
- R4: An accepted insert and a taken release in the same cycle are netted. `free_total` is unchanged, and each named thread moves by its own amount, which is zero when both name the same thread.
- R5: `ins_ready` is low when `free_total` is 0, when the thread named by `ins_tid` is full, or when `ins_tid` is not a valid thread number. An insert offered while not ready changes no count, and `ins_err` is high in the following cycle only.
- R6: With `pol_sel` at 0 or 3 (open policy), each thread's limit equals NUM_ENTRIES.
- R7: With `pol_sel` at 1 (even split), each limit equals NUM_ENTRIES divided by `act_threads` with truncation. An `act_threads` value of 0, or one above NUM_THREADS, counts as NUM_THREADS.
- R8: With `pol_sel` at 2 (percentage), each limit equals min(`thr_pct`,100) times NUM_ENTRIES divided by 100, truncated. When `act_threads` equals 1, the limit is NUM_ENTRIES instead.
- R9: A thread's free count equals its limit minus its occupancy, or 0 when the occupancy is at or above the limit. The thread is full exactly when that count is 0. Limits reflect the control inputs of the previous cycle.
- R10: The sum of the occupancies of all threads always equals NUM_ENTRIES minus `free_total`. `full_total` is high exactly when `free_total` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 2 | Sharing policy: 0/3 open, 1 even split, 2 percentage |
| thr_pct | input | 7 | Per-thread share in percent for the percentage policy |
| act_threads | input | AW | Number of active threads |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TIDW | Thread of the insert request |
| ins_ready | output | 1 | Insert can be taken this cycle |
| rel_valid | input | 1 | Release of one slot |
| rel_tid | input | TIDW | Thread of the release |
| free_total | output | CW | Free slots in the whole queue |
| full_total | output | 1 | Whole queue occupied |
| thr_free | output | NUM_THREADS*CW | Free count per thread, thread i at bits [i*CW +: CW] |
| thr_full | output | NUM_THREADS | Full flag per thread |
| ins_err | output | 1 | An insert was refused in the previous cycle |

## Verification
An insert and a release can fall in the same cycle, so the netting of the two is the main concurrency to exercise. The bench drives both together on two different threads, on the same thread, and while the queue is completely occupied. The last case checks that the insert is refused and flagged while the release still frees a slot. After each such cycle, every per-thread free count and the global free count are compared against a reference model kept in the bench. That model applies the policy arithmetic and the netting rule.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;
  typedef enum logic [1:0] {
    SHARE_OPEN  = 2'd0,
    SHARE_SPLIT = 2'd1,
    SHARE_PCT   = 2'd2,
    SHARE_OPEN2 = 2'd3
  } share_e;

  localparam int PCT_W   = 7;
  localparam int PCT_MAX = 100;
endpackage

// File: rtl/iq_limit_calc.sv
module iq_limit_calc
  import iq_alloc_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_THREADS = 4,
  parameter int CW = 6,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pol_sel,
  input  logic [PCT_W-1:0] thr_pct,
  input  logic [AW-1:0]    act_threads,
  output logic [CW-1:0]    limit_q
);
  localparam int PW = PCT_W + CW + 1;

  logic [AW-1:0]    act_eff;
  logic [CW-1:0]    split_lim;
  logic [PCT_W-1:0] pct_c;
  logic [PW-1:0]    prod;
  logic [CW-1:0]    pct_lim;
  logic [CW-1:0]    lim_d;
  share_e           pol;

  assign pol = share_e'(pol_sel);

  always_comb begin
    if (act_threads == '0 || act_threads > AW'(NUM_THREADS))
      act_eff = AW'(NUM_THREADS);
    else
      act_eff = act_threads;
  end

  // quotient table for each possible divisor
  always_comb begin
    split_lim = CW'(NUM_ENTRIES);
    for (int k = 1; k <= NUM_THREADS; k++) begin
      if (act_eff == AW'(k)) split_lim = CW'(NUM_ENTRIES / k);
    end
  end

  always_comb begin
    pct_c   = (thr_pct > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : thr_pct;
    prod    = PW'(pct_c) * PW'(NUM_ENTRIES);
    pct_lim = CW'(prod / PW'(PCT_MAX));
  end

  always_comb begin
    case (pol)
      SHARE_SPLIT: lim_d = split_lim;
      SHARE_PCT:   lim_d = (act_threads == AW'(1)) ? CW'(NUM_ENTRIES) : pct_lim;
      default:     lim_d = CW'(NUM_ENTRIES);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= CW'(NUM_ENTRIES);
    else        limit_q <= lim_d;
  end
endmodule

// File: rtl/iq_thread_ctr.sv
module iq_thread_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic          inc,
  input  logic          dec_req,
  output logic          dec_done,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] free,
  output logic          full
);
  logic [CW-1:0] occ_q;

  assign dec_done = dec_req && (occ_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (inc && !dec_done) occ_q <= occ_q + CW'(1);
    else if (!inc && dec_done) occ_q <= occ_q - CW'(1);
  end

  assign occ  = occ_q;
  assign free = (limit > occ_q) ? (limit - occ_q) : '0;
  assign full = (free == '0);
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc
  import iq_alloc_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_THREADS = 4,
  localparam int CW   = $clog2(NUM_ENTRIES + 1),
  localparam int TIDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int AW   = $clog2(NUM_THREADS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                pol_sel,
  input  logic [PCT_W-1:0]          thr_pct,
  input  logic [AW-1:0]             act_threads,
  input  logic                      ins_valid,
  input  logic [TIDW-1:0]           ins_tid,
  output logic                      ins_ready,
  input  logic                      rel_valid,
  input  logic [TIDW-1:0]           rel_tid,
  output logic [CW-1:0]             free_total,
  output logic                      full_total,
  output logic [NUM_THREADS*CW-1:0] thr_free,
  output logic [NUM_THREADS-1:0]    thr_full,
  output logic                      ins_err
);
  logic [CW-1:0]             limit_q;
  logic [CW-1:0]             gfree_q;
  logic [NUM_THREADS-1:0]    inc_vec;
  logic [NUM_THREADS-1:0]    rel_vec;
  logic [NUM_THREADS-1:0]    dec_vec;
  logic [NUM_THREADS-1:0]    full_vec;
  logic [NUM_THREADS*CW-1:0] occ_flat;
  logic [NUM_THREADS*CW-1:0] free_flat;
  logic                      tid_ok;
  logic                      tid_full;
  logic                      ins_fire;
  logic                      dec_any;
  logic                      err_q;

  iq_limit_calc #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .CW(CW), .AW(AW)
  ) u_lim (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .thr_pct(thr_pct),
    .act_threads(act_threads), .limit_q(limit_q)
  );

  always_comb begin
    tid_ok   = 1'b0;
    tid_full = 1'b1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (ins_tid == TIDW'(t)) begin
        tid_ok   = 1'b1;
        tid_full = full_vec[t];
      end
    end
  end

  assign ins_ready = tid_ok && !tid_full && (gfree_q != '0);
  assign ins_fire  = ins_valid && ins_ready;
  assign dec_any   = |dec_vec;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    assign inc_vec[g] = ins_fire && (ins_tid == TIDW'(g));
    assign rel_vec[g] = rel_valid && (rel_tid == TIDW'(g));

    iq_thread_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .limit(limit_q),
      .inc(inc_vec[g]), .dec_req(rel_vec[g]), .dec_done(dec_vec[g]),
      .occ(occ_flat[g*CW +: CW]), .free(free_flat[g*CW +: CW]),
      .full(full_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gfree_q <= CW'(NUM_ENTRIES);
      err_q   <= 1'b0;
    end else begin
      if (dec_any && !ins_fire)      gfree_q <= gfree_q + CW'(1);
      else if (ins_fire && !dec_any) gfree_q <= gfree_q - CW'(1);
      err_q <= ins_valid && !ins_ready;
    end
  end

  assign free_total = gfree_q;
  assign full_total = (gfree_q == '0);
  assign thr_free   = free_flat;
  assign thr_full   = full_vec;
  assign ins_err    = err_q;
endmodule

// File: rtl/iq_alloc_chk.sv
module iq_alloc_chk #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_THREADS = 4,
  parameter int CW = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ins_valid,
  input logic                      ins_ready,
  input logic                      rel_valid,
  input logic [CW-1:0]             free_total,
  input logic                      full_total,
  input logic                      ins_err,
  input logic [NUM_THREADS*CW-1:0] occ_flat
);
  logic [CW+7:0] occ_sum;

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      occ_sum = occ_sum + (CW+8)'(occ_flat[t*CW +: CW]);
  end

  AST_ACCEPT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !rel_valid) |=> free_total == $past(free_total) - CW'(1)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !rel_valid) |=> $stable(free_total)); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full_total |-> !ins_ready); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> $past(ins_valid && !ins_ready)); // R5
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !rel_valid) |=> $stable(free_total)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_total <= CW'(NUM_ENTRIES)); // R10
  AST_OCC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum == (CW+8)'(NUM_ENTRIES) - (CW+8)'(free_total)); // R10
endmodule

bind iq_alloc iq_alloc_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .rel_valid(rel_valid), .free_total(free_total), .full_total(full_total),
  .ins_err(ins_err), .occ_flat(occ_flat)
);

// File: tb/tb_iq_alloc.sv
module tb_iq_alloc;
  localparam int N = 32;
  localparam int T = 4;
  localparam int CW = 6;
  localparam int TIDW = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pol_sel = 2'd0;
  logic [6:0] thr_pct = 7'd50;
  logic [AW-1:0] act_threads = AW'(T);
  logic ins_valid = 1'b0;
  logic [TIDW-1:0] ins_tid = '0;
  logic ins_ready;
  logic rel_valid = 1'b0;
  logic [TIDW-1:0] rel_tid = '0;
  logic [CW-1:0] free_total;
  logic full_total;
  logic [T*CW-1:0] thr_free;
  logic [T-1:0] thr_full;
  logic ins_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_occ[T];
  int m_gfree;
  int m_lim;

  always #4 clk = ~clk;

  iq_alloc #(.NUM_ENTRIES(N), .NUM_THREADS(T)) dut (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .thr_pct(thr_pct),
    .act_threads(act_threads), .ins_valid(ins_valid), .ins_tid(ins_tid),
    .ins_ready(ins_ready), .rel_valid(rel_valid), .rel_tid(rel_tid),
    .free_total(free_total), .full_total(full_total), .thr_free(thr_free),
    .thr_full(thr_full), .ins_err(ins_err)
  );

  function automatic int exp_lim(int pol, int pct, int act);
    int a, p;
    if (pol == 1) begin
      a = (act == 0 || act > T) ? T : act;
      return N / a;
    end else if (pol == 2) begin
      if (act == 1) return N;
      p = (pct > 100) ? 100 : pct;
      return (p * N) / 100;
    end
    return N;
  endfunction

  function automatic int m_free(int t);
    return (m_lim > m_occ[t]) ? m_lim - m_occ[t] : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "free_total", int'(free_total), m_gfree);
    chk(req, "full_total", int'(full_total), (m_gfree == 0) ? 1 : 0);
    for (int t = 0; t < T; t++) begin
      chk(req, $sformatf("thr_free[%0d]", t), int'(thr_free[t*CW +: CW]), m_free(t));
      chk(req, $sformatf("thr_full[%0d]", t), int'(thr_full[t]), (m_free(t) == 0) ? 1 : 0);
    end
  endtask

  // one clock cycle with the given request; updates the reference model
  task automatic cyc(string req, bit iv, int it, bit rv, int rt);
    bit acc, dec;
    ins_valid = iv; ins_tid = TIDW'(it);
    rel_valid = rv; rel_tid = TIDW'(rt);
    acc = iv && (m_gfree != 0) && (m_free(it) != 0);
    dec = rv && (m_occ[rt] > 0);
    #1;
    if (iv) chk(req, "ins_ready", int'(ins_ready), int'(acc));
    @(posedge clk); #1;
    if (acc) m_occ[it]++;
    if (dec) m_occ[rt]--;
    if (acc && !dec) m_gfree--;
    if (dec && !acc) m_gfree++;
    m_lim = exp_lim(int'(pol_sel), int'(thr_pct), int'(act_threads));
    ins_valid = 0; rel_valid = 0;
    chk(req, "ins_err", int'(ins_err), (iv && !acc) ? 1 : 0);
  endtask

  task automatic t_reset;
    chk_all("R1");
    chk("R1", "ins_err", int'(ins_err), 0);
  endtask

  task automatic t_insert_release;
    for (int i = 0; i < 3; i++) cyc("R2", 1, 0, 0, 0);
    chk_all("R2");
    chk("R2", "free_total", int'(free_total), 29);
    cyc("R3", 0, 0, 1, 0);
    chk_all("R3");
    cyc("R3", 0, 0, 1, 2);  // thread 2 holds nothing: ignored
    chk_all("R3");
    chk("R3", "empty release free_total", int'(free_total), 30);
  endtask

  task automatic t_net;
    cyc("R4", 1, 1, 1, 0);
    chk_all("R4");
    chk("R4", "net free_total", int'(free_total), 30);
    cyc("R4", 1, 0, 1, 0);
    chk_all("R4");
    chk("R4", "same-thread thr_free[0]", int'(thr_free[0 +: CW]), 31);
  endtask

  task automatic t_split;
    pol_sel = 2'd1; act_threads = 3'd4;
    cyc("R7", 0, 0, 0, 0);
    chk_all("R7");
    for (int i = 0; i < 8; i++) cyc("R7", 1, 3, 0, 0);
    chk_all("R9");
    chk("R9", "thr_full[3]", int'(thr_full[3]), 1);
    cyc("R5", 1, 3, 0, 0);  // refused
    chk_all("R5");
    act_threads = 3'd3;
    cyc("R7", 0, 0, 0, 0);
    chk("R7", "thr_free[3] act=3", int'(thr_free[3*CW +: CW]), 2);
    act_threads = 3'd0;
    cyc("R7", 0, 0, 0, 0);
    chk_all("R7");
    pol_sel = 2'd3;
    cyc("R6", 0, 0, 0, 0);
    chk_all("R6");
  endtask

  task automatic t_pct;
    pol_sel = 2'd2; thr_pct = 7'd30; act_threads = 3'd2;
    cyc("R8", 0, 0, 0, 0);
    chk("R8", "thr_free[3] 30pct", int'(thr_free[3*CW +: CW]), 1);
    chk_all("R8");
    act_threads = 3'd1;
    cyc("R8", 0, 0, 0, 0);
    chk("R8", "thr_free[3] single", int'(thr_free[3*CW +: CW]), 24);
    act_threads = 3'd2; thr_pct = 7'd120;
    cyc("R8", 0, 0, 0, 0);
    chk_all("R8");
    thr_pct = 7'd10;
    cyc("R9", 0, 0, 0, 0);
    chk("R9", "over-limit thr_free[3]", int'(thr_free[3*CW +: CW]), 0);
    chk_all("R9");
    cyc("R9", 1, 3, 0, 0);
    chk_all("R9");
  endtask

  task automatic t_global_full;
    int guard;
    pol_sel = 2'd0;
    cyc("R6", 0, 0, 0, 0);
    guard = 0;
    while (m_gfree > 0 && guard < 64) begin
      cyc("R10", 1, 2, 0, 0);
      guard++;
    end
    chk_all("R10");
    chk("R10", "full_total", int'(full_total), 1);
    cyc("R5", 1, 1, 0, 0);
    chk_all("R5");
    cyc("R4", 1, 1, 1, 2);  // release taken, insert refused
    chk_all("R4");
    chk("R4", "free_total after full", int'(free_total), 1);
    cyc("R5", 1, 1, 0, 0);
    chk_all("R10");
  endtask

  initial begin
    for (int t = 0; t < T; t++) m_occ[t] = 0;
    m_gfree = N; m_lim = N;
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_insert_release();
    t_net();
    t_split();
    t_pct();
    t_global_full();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule